// File: doc/BRIEF.md
# Store-Gathering FIFO Writer

This block sits on a CPU store path and turns a stream of small stores, all aimed at one fixed port address, into whole 32-byte memory bursts. Bytes are packed into a gather buffer in the order they arrive. When the buffer fills, the complete chunk is written to memory at the current FIFO write pointer. The pointer then steps forward by one chunk. When it passes the top of the ring it reloads from the base and raises a wrap flag. Software only stores to the port address. The hardware handles all addressing.

Three 32-bit registers hold the ring base, the ring top and the write pointer. They are written through the same store port at their own addresses. Their contents are published on output ports, so a reader on the far side can track how far the producer has advanced. Stores to any other address leave the block unchanged on a bypass output.

Top module: `wg_fifo_writer`

## Requirements
- R1: A store to `PORT_ADDR` is gathered. `st_size` 0 carries 1 byte, `st_size` 1 carries 2 bytes, and `st_size` 2 or 3 carries 4 bytes, taken from the low bytes of `st_data`. The most significant of those bytes enters the buffer first.
- R2: When 32 bytes have been gathered, one burst is issued on `mem_valid`/`mem_addr`/`mem_data`. Buffer byte 0 sits in `mem_data[255:248]` and byte 31 in `mem_data[7:0]`. `mem_addr` equals the write pointer at the moment of issue.
- R3: A store that would cross the 32-byte boundary is split. Its leading bytes complete the current chunk, and its remaining bytes become bytes 0.. of the next chunk.
- R4: A chunk is committed on a clock edge where `mem_valid` and `mem_ready` are both high. After the commit the write pointer advances by 32.
- R5: If the pointer that was just committed is at or beyond `top`, the pointer reloads with `base` instead of advancing.
- R6: A reload from base sets bit 27 of `wptr_o`, the wrap flag.
- R7: The wrap flag is cleared by the next accepted port store on a later edge. An accepted port store on the same edge as a wrapping commit leaves the flag set. Writing the pointer register also clears the flag.
- R8: Stores to `BASE_REG`, `TOP_REG` and `WPTR_REG` load those registers. Bits 4:0 and bits 31:27 of the written data are dropped, so the stored values are 32-byte aligned, and bit 27 written to the pointer does not set the flag.
- R9: While a chunk waits and `mem_ready` is low, port stores and register stores see `st_ready` low. The pending burst holds its address and data stable until it is taken.
- R10: A store to any other address appears unchanged on `byp_valid`/`byp_addr`/`byp_data`/`byp_size` in the same cycle, with `st_ready` high. It has no effect on the gather buffer or the pointers.
- R11: After reset all registers read zero, the flag is clear, no burst is pending and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | CPU store request |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data, right-aligned |
| st_size | input | 2 | Store size code |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| byp_valid | output | 1 | Non-FIFO store passing through |
| byp_addr | output | 32 | Bypassed address |
| byp_data | output | 32 | Bypassed data |
| byp_size | output | 2 | Bypassed size code |
| mem_valid | output | 1 | Chunk burst pending |
| mem_addr | output | 32 | Burst target address |
| mem_data | output | 256 | Burst payload |
| mem_ready | input | 1 | Memory takes the burst |
| cfg_base | output | 32 | Ring base register |
| cfg_top | output | 32 | Ring top register |
| wptr_o | output | 32 | Write pointer with wrap flag in bit 27 |

## Verification
Two events can land on the same edge: a wrapping commit, which sets the flag, and an accepted port store, which clears it. The bench sets this up by parking a full chunk at the top address with `mem_ready` held low. It then raises `mem_ready` in the same cycle that it presents a port store. The flag must read set after that edge and clear only after the following store. A randomly paced `mem_ready` also makes commits coincide with stores throughout the random phase, and a bench model that gives the set priority judges every cycle.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } st_size_e;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/wg_gather.sv
module wg_gather #(
  parameter int CHUNK_BYTES = 32,
  parameter int OFF_W       = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc,
  input  logic [31:0]              data,
  input  logic [2:0]               nbytes,
  output logic                     fire,
  output logic [CHUNK_BYTES*8-1:0] chunk
);
  localparam int CW    = CHUNK_BYTES * 8;
  localparam int SUM_W = OFF_W + 1;

  logic [CW-1:0]    buf_q, buf_n, cur_c, ovf_c;
  logic [OFF_W-1:0] fill_q, fill_n;
  logic [SUM_W-1:0] sum_c;
  logic             en;

  always_comb begin
    int       pos;
    int       src;
    logic [7:0] byt;
    cur_c = buf_q;
    ovf_c = '0;
    pos   = 0;
    src   = 0;
    byt   = '0;
    sum_c = SUM_W'(fill_q) + SUM_W'(nbytes);
    for (int i = 0; i < 4; i++) begin
      if (i < int'(nbytes)) begin
        src = int'(nbytes) - 1 - i;
        byt = data[src*8 +: 8];
        pos = int'(fill_q) + i;
        if (pos < CHUNK_BYTES) cur_c[(CHUNK_BYTES-1-pos)*8 +: 8] = byt;
        else                   ovf_c[(2*CHUNK_BYTES-1-pos)*8 +: 8] = byt;
      end
    end
  end

  assign fire  = acc && (sum_c >= SUM_W'(CHUNK_BYTES));
  assign chunk = cur_c;
  assign en    = acc;

  always_comb begin
    buf_n  = buf_q;
    fill_n = fill_q;
    if (en) begin
      buf_n  = fire ? ovf_c : cur_c;
      fill_n = sum_c[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      fill_q <= '0;
    end else if (en) begin
      buf_q  <= buf_n;
      fill_q <= fill_n;
    end
  end

  // R1
  gather_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(fill_q) && $stable(buf_q)));
endmodule

// File: rtl/wg_ptr.sv
module wg_ptr #(
  parameter int ADDR_W = 27,
  parameter int OFF_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_base,
  input  logic                    wr_top,
  input  logic                    wr_wptr,
  input  logic [ADDR_W-OFF_W-1:0] wfield,
  input  logic                    commit,
  input  logic                    port_acc,
  output logic [ADDR_W-OFF_W-1:0] base,
  output logic [ADDR_W-OFF_W-1:0] top,
  output logic [ADDR_W-OFF_W-1:0] wp,
  output logic                    flag
);
  localparam int FW = ADDR_W - OFF_W;

  logic [FW-1:0] base_q, top_q, wp_q, base_n, top_n, wp_n;
  logic          flag_q, flag_n, wrap_c;

  assign wrap_c = commit && (wp_q >= top_q);

  always_comb begin
    base_n = wr_base ? wfield : base_q;
    top_n  = wr_top  ? wfield : top_q;
    wp_n   = wp_q;
    if (commit)       wp_n = wrap_c ? base_q : wp_q + FW'(1);
    else if (wr_wptr) wp_n = wfield;
    flag_n = flag_q;
    if (wrap_c)                   flag_n = 1'b1;
    else if (port_acc || wr_wptr) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      top_q  <= '0;
      wp_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_base)           base_q <= base_n;
      if (wr_top)            top_q  <= top_n;
      if (commit || wr_wptr) wp_q   <= wp_n;
      flag_q <= flag_n;
    end
  end

  assign base = base_q;
  assign top  = top_q;
  assign wp   = wp_q;
  assign flag = flag_q;

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wrap_c) |=> (wp_q == $past(wp_q) + FW'(1)));
  // R5
  ptr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_c |=> (wp_q == $past(base_q)));
  // R6
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_c |=> flag_q);
  // R7
  wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && !commit) |=> !flag_q);
endmodule

// File: rtl/wg_fifo_writer.sv
module wg_fifo_writer
  import wg_pkg::*;
#(
  parameter int          CHUNK_BYTES = 32,
  parameter int          ADDR_W      = 27,
  parameter logic [31:0] PORT_ADDR   = 32'h0000_2000,
  parameter logic [31:0] BASE_REG    = 32'h0000_1000,
  parameter logic [31:0] TOP_REG     = 32'h0000_1004,
  parameter logic [31:0] WPTR_REG    = 32'h0000_1008
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  input  logic [31:0]              st_addr,
  input  logic [31:0]              st_data,
  input  logic [1:0]               st_size,
  output logic                     st_ready,
  output logic                     byp_valid,
  output logic [31:0]              byp_addr,
  output logic [31:0]              byp_data,
  output logic [1:0]               byp_size,
  output logic                     mem_valid,
  output logic [31:0]              mem_addr,
  output logic [CHUNK_BYTES*8-1:0] mem_data,
  input  logic                     mem_ready,
  output logic [31:0]              cfg_base,
  output logic [31:0]              cfg_top,
  output logic [31:0]              wptr_o
);
  localparam int OFF_W = $clog2(CHUNK_BYTES);
  localparam int FW    = ADDR_W - OFF_W;
  localparam int HI_W  = 31 - ADDR_W;
  localparam int CW    = CHUNK_BYTES * 8;

  logic          is_port, is_base, is_top, is_wptr, is_reg;
  logic          port_acc, reg_acc, commit, g_fire;
  logic [CW-1:0] g_chunk, chunk_q, chunk_n;
  logic          pend_q, pend_n;
  logic [FW-1:0] base_f, top_f, wp_f;
  logic          wflag;

  assign is_port = (st_addr == PORT_ADDR);
  assign is_base = (st_addr == BASE_REG);
  assign is_top  = (st_addr == TOP_REG);
  assign is_wptr = (st_addr == WPTR_REG);
  assign is_reg  = is_base || is_top || is_wptr;

  assign commit = pend_q && mem_ready;

  always_comb begin
    if (is_port)     st_ready = !pend_q || mem_ready;
    else if (is_reg) st_ready = !pend_q;
    else             st_ready = 1'b1;
  end

  assign port_acc = st_valid && is_port && st_ready;
  assign reg_acc  = st_valid && is_reg && !pend_q;

  assign byp_valid = st_valid && !is_port && !is_reg;
  assign byp_addr  = st_addr;
  assign byp_data  = st_data;
  assign byp_size  = st_size;

  wg_gather #(.CHUNK_BYTES(CHUNK_BYTES), .OFF_W(OFF_W)) u_gather (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (port_acc),
    .data   (st_data),
    .nbytes (size_to_bytes(st_size)),
    .fire   (g_fire),
    .chunk  (g_chunk)
  );

  wg_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_base  (reg_acc && is_base),
    .wr_top   (reg_acc && is_top),
    .wr_wptr  (reg_acc && is_wptr),
    .wfield   (st_data[ADDR_W-1:OFF_W]),
    .commit   (commit),
    .port_acc (port_acc),
    .base     (base_f),
    .top      (top_f),
    .wp       (wp_f),
    .flag     (wflag)
  );

  always_comb begin
    pend_n  = pend_q;
    chunk_n = chunk_q;
    if (g_fire) begin
      pend_n  = 1'b1;
      chunk_n = g_chunk;
    end else if (commit) begin
      pend_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      chunk_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (g_fire) chunk_q <= chunk_n;
    end
  end

  assign mem_valid = pend_q;
  assign mem_data  = chunk_q;
  assign mem_addr  = {{(32-ADDR_W){1'b0}}, wp_f, {OFF_W{1'b0}}};
  assign cfg_base  = {{(32-ADDR_W){1'b0}}, base_f, {OFF_W{1'b0}}};
  assign cfg_top   = {{(32-ADDR_W){1'b0}}, top_f, {OFF_W{1'b0}}};
  assign wptr_o    = {{HI_W{1'b0}}, wflag, wp_f, {OFF_W{1'b0}}};

  // R9
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_addr)));
  // R2
  fire_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_fire |=> mem_valid);
  // R10
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_valid && !commit) |=> $stable(wptr_o));
endmodule

// File: tb/wg_fifo_writer_tb.sv
`timescale 1ns/1ps
module wg_fifo_writer_tb;
  localparam logic [31:0] PORT = 32'h0000_2000;
  localparam logic [31:0] RB   = 32'h0000_1000;
  localparam logic [31:0] RT   = 32'h0000_1004;
  localparam logic [31:0] RW   = 32'h0000_1008;
  localparam logic [31:0] MSK  = 32'h07FF_FFE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [1:0] st_size = '0;
  logic st_ready, byp_valid, mem_valid;
  logic [31:0] byp_addr, byp_data, mem_addr, cfg_base, cfg_top, wptr_o;
  logic [1:0] byp_size;
  logic [255:0] mem_data;
  logic mem_ready = 1'b0;

  always #10 clk = ~clk;

  wg_fifo_writer u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_size(st_size), .st_ready(st_ready),
    .byp_valid(byp_valid), .byp_addr(byp_addr), .byp_data(byp_data),
    .byp_size(byp_size), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready), .cfg_base(cfg_base),
    .cfg_top(cfg_top), .wptr_o(wptr_o)
  );

  int checks = 0;
  int errs = 0;
  int rdy_mode = 1;
  bit run_mon = 1'b0;
  logic [7:0] q[$];
  logic [31:0] m_base = '0, m_top = '0, m_wp = '0;
  logic m_flag = 1'b0;
  bit nx_commit = 1'b0, nx_store = 1'b0;
  int nx_rsel = 0;
  logic [31:0] nx_rdat = '0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wptr(input logic [31:0] wp, input logic f);
    return wp | (f ? 32'h0800_0000 : 32'h0);
  endfunction

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // memory side and per-cycle checks
  always @(negedge clk) begin
    if (run_mon) begin
      case (rdy_mode)
        0: mem_ready = ($urandom_range(0, 2) != 0);
        1: mem_ready = 1'b0;
        default: mem_ready = 1'b1;
      endcase
      // R4 R5 R6 R7
      chk(wptr_o == exp_wptr(m_wp, m_flag), "R4 R5 R6 R7 wptr_o", wptr_o, exp_wptr(m_wp, m_flag));
      if (mem_valid && mem_ready) begin
        logic [255:0] e;
        e = '0;
        if (q.size() < 32) chk(1'b0, "R2 chunk without 32 bytes", q.size(), 32);
        else begin
          for (int k = 0; k < 32; k++) e[(31-k)*8 +: 8] = q.pop_front();
          // R1 R2 R3
          chk(mem_data == e, "R1 R2 R3 mem_data", mem_data, e);
        end
        // R4
        chk(mem_addr == m_wp, "R4 mem_addr", mem_addr, m_wp);
        nx_commit = 1'b1;
      end
    end
  end

  // bench model of the pointer registers
  always @(posedge clk) begin
    if (nx_commit && (m_wp >= m_top)) begin
      m_wp = m_base;
      m_flag = 1'b1;
    end else begin
      if (nx_commit) m_wp = m_wp + 32;
      if (nx_store || nx_rsel == 3) m_flag = 1'b0;
    end
    case (nx_rsel)
      1: m_base = nx_rdat & MSK;
      2: m_top  = nx_rdat & MSK;
      3: m_wp   = nx_rdat & MSK;
      default: ;
    endcase
    nx_commit = 1'b0;
    nx_store = 1'b0;
    nx_rsel = 0;
  end

  task automatic port_store(input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    st_valid = 1'b1; st_addr = PORT; st_data = d; st_size = sz;
    #2;
    while (!st_ready) begin @(negedge clk); #2; end
    for (int i = nb(sz) - 1; i >= 0; i--) q.push_back(d[8*i +: 8]);
    nx_store = 1'b1;
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [31:0] a, input logic [31:0] d, input int sel);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_size = 2'd2;
    #2;
    while (!st_ready) begin @(negedge clk); #2; end
    nx_rsel = sel; nx_rdat = d;
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic drain();
    rdy_mode = 2;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #3000000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #5;
    // R11 reset state
    chk(wptr_o == 32'h0 && cfg_base == 32'h0 && cfg_top == 32'h0, "R11 regs after reset", {cfg_base, cfg_top, wptr_o}, 0);
    chk(!mem_valid && st_ready, "R11 idle after reset", {mem_valid, st_ready}, 2'b01);
    @(negedge clk); rst_n = 1'b1;
    run_mon = 1'b1;

    // R8 alignment and masking
    reg_write(RB, 32'hF000_011F, 1);
    reg_write(RT, 32'h0000_015F, 2);
    reg_write(RW, 32'h0800_0107, 3);
    #5;
    chk(cfg_base == 32'h0000_0100, "R8 base masked", cfg_base, 32'h100);
    chk(cfg_top == 32'h0000_0140, "R8 top masked", cfg_top, 32'h140);
    chk(wptr_o == 32'h0000_0100, "R8 wptr masked, bit 27 not set", wptr_o, 32'h100);

    // R10 bypass
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h5555_0040; st_data = 32'hCAFE_F00D; st_size = 2'd1;
    #2;
    chk(byp_valid && byp_addr == 32'h5555_0040 && byp_data == 32'hCAFE_F00D && byp_size == 2'd1 && st_ready,
        "R10 bypass fields", {byp_valid, byp_addr, byp_data, byp_size}, {1'b1, 32'h5555_0040, 32'hCAFE_F00D, 2'd1});
    @(posedge clk); #1; st_valid = 1'b0;
    #5;
    chk(wptr_o == 32'h0000_0100 && !mem_valid, "R10 bypass leaves state", wptr_o, 32'h100);

    // R3 straddle: 30 bytes then a word
    rdy_mode = 2;
    for (int i = 0; i < 15; i++) port_store(32'h0000_0000 | (i * 16'h0101 + 16'h1020), 2'd1);
    port_store(32'hA1B2_C3D4, 2'd2);
    repeat (3) @(posedge clk);
    #5;
    chk(q.size() == 2 && q[0] == 8'hC3 && q[1] == 8'hD4, "R3 carry bytes kept", q.size(), 2);

    // R9 back-pressure, then R7 same-edge wrap versus store
    drain();
    reg_write(RW, 32'h0000_0140, 3);
    rdy_mode = 1;
    while (q.size() < 32) port_store($urandom, 2'd0);
    @(negedge clk); #2;
    chk(mem_valid && mem_addr == 32'h140, "R9 burst waiting at top", mem_addr, 32'h140);
    begin
      logic [255:0] snap;
      snap = mem_data;
      st_valid = 1'b1; st_addr = PORT; st_data = 32'h77; st_size = 2'd0;
      #1;
      chk(!st_ready, "R9 port store stalled", st_ready, 0);
      st_addr = RB;
      #1;
      chk(!st_ready, "R9 register store stalled", st_ready, 0);
      st_valid = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      chk(mem_valid && mem_data == snap, "R9 burst data held", mem_data, snap);
    end
    rdy_mode = 2;
    port_store(32'h0000_00EE, 2'd0);
    #4;
    chk(wptr_o == 32'h0800_0100, "R5 R6 R7 same-edge wrap keeps flag", wptr_o, 32'h0800_0100);
    port_store(32'h0000_00EF, 2'd0);
    #4;
    chk(wptr_o == 32'h0000_0100, "R7 next store clears flag", wptr_o, 32'h100);

    // random phase
    reg_write(RB, 32'h0000_0400, 1);
    reg_write(RT, 32'h0000_04E0, 2);
    reg_write(RW, 32'h0000_0400, 3);
    rdy_mode = 0;
    for (int n = 0; n < 2500; n++) begin
      if ($urandom_range(0, 19) == 0) begin
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h0000_3000 + ($urandom_range(0, 15) << 2);
        st_data = $urandom; st_size = 2'($urandom_range(0, 3));
        #2;
        // R10
        chk(byp_valid && st_ready, "R10 random bypass", {byp_valid, st_ready}, 2'b11);
        @(posedge clk); #1; st_valid = 1'b0;
      end else begin
        port_store($urandom, 2'($urandom_range(0, 3)));
      end
    end
    drain();
    chk(q.size() < 32 && !mem_valid, "R2 all full chunks issued", q.size(), 0);
    run_mon = 1'b0;
    finish_run();
  end
endmodule